// File: doc/BRIEF.md
# Normal-Basis Field Inverter (Type-I, Sequential)

This block returns the multiplicative inverse of an element of GF(2^M) held in Type-I optimal normal basis, where M+1 is prime and 2 generates the nonzero residues modulo M+1. Bit i of an operand is the coefficient of beta^(2^i). The inverse is formed as B^(2^M - 2), which equals the product of the squares B^2, B^4, ..., B^(2^(M-1)). Each square costs nothing: it is one cyclic rotation of a holding register.

The products are made by one bit-serial multiplier that is used again for every factor. Operands are permuted into a cyclic polynomial ring of M+1 positions. There, multiplication is a rotate-and-accumulate over M+1 clocks. Before the product is written back as the running value, a term in position zero is folded into all other positions. The running product returns to the multiplier as its serial operand for the next factor. After M-2 multiplications the value is permuted back to normal basis.

The user drives a one-cycle start pulse with the operand. The block then answers with a one-cycle done pulse, and the inverse stays on its output until the next result.

Top module: `onbInv`

## Requirements
- R1: While reset is asserted and after it is released, before any start, done is 0 and inv is all zeros.
- R2: For every nonzero operand B, the result multiplied by B in the field equals the normal-basis identity, which is the all-ones vector (the constant 1 is the sum of all basis elements).
- R3: Inverting a result again gives back the original operand.
- R4: A zero operand produces an all-zero result, and done is raised after the same latency as for any other operand.
- R5: done rises exactly 2 + (M-2)*(M+3) rising edges after the edge that samples start: one squaring load, then M-2 multiply rounds of M+3 cycles each (operand load, M+1 accumulate steps, write-back), then one output edge.
- R6: done is high for exactly one cycle, and inv changes only on the edge that raises done.
- R7: A start pulse that arrives while an inversion is in progress is ignored: the result and the latency are those of the operation already running.
- R8: The same code gives correct inverses for more than one field size, shown at M=4 and M=10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; sampled only when idle |
| opB | input | M | Operand in normal basis, sampled together with start |
| done | output | 1 | One-cycle pulse when inv is updated |
| inv | output | M | Inverse in normal basis, held until the next done |

## Verification
The assertions assume that start is a short pulse and that, after reset, the controller sees it only in the idle state or as an ignored request. They also assume that the serial operand register is never in its accumulate window outside the M+1 counted steps. The stimulus raises start for exactly one cycle and changes opB only while start is low. It raises start during an inversion on purpose, in one scenario only, to show that the request is dropped. Every nonzero element at both field sizes, together with zero, is run through the block.

// File: rtl/onbInvPkg.sv
package onbInvPkg;

  // Strobes from the sequencer to the datapath, at most one high per cycle
  typedef struct packed {
    logic ldB;     // capture operand into the rotate register
    logic sqInit;  // first square straight into the running product
    logic ldD;     // next square into the parallel operand, clear accumulator
    logic accEn;   // one rotate-and-accumulate step
    logic wb;      // corrected product back into the running register
    logic fin;     // publish result, raise done
  } invStrb_t;

  // Position of basis element beta^(2^idx) inside the cyclic ring of size modP
  function automatic int expPos(input int idx, input int modP);
    int r;
    r = 1;
    for (int k = 0; k < idx; k++) r = (r * 2) % modP;
    return r;
  endfunction

endpackage

// File: rtl/onbInvCtrl.sv
module onbInvCtrl
  import onbInvPkg::*;
#(
  parameter int M = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output invStrb_t strb
);

  localparam int CW = $clog2(M + 1);
  localparam int MW = $clog2(M);
  localparam logic [CW-1:0] LAST_STEP = CW'(M);
  localparam logic [MW-1:0] MUL_ROUNDS = MW'(M - 2);

  typedef enum logic [2:0] {
    S_IDLE, S_SQ, S_LDD, S_ACC, S_WB, S_FIN
  } invState_t;

  invState_t state;
  logic [CW-1:0] stepCnt;
  logic [MW-1:0] mulLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      mulLeft <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          state   <= S_SQ;
          mulLeft <= MUL_ROUNDS;
        end
        S_SQ:   state <= (mulLeft == '0) ? S_FIN : S_LDD;
        S_LDD: begin
          state   <= S_ACC;
          stepCnt <= '0;
        end
        S_ACC: begin
          if (stepCnt == LAST_STEP) state <= S_WB;
          else stepCnt <= stepCnt + 1'b1;
        end
        S_WB: begin
          mulLeft <= mulLeft - 1'b1;
          state   <= (mulLeft == MW'(1)) ? S_FIN : S_LDD;
        end
        S_FIN:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.ldB    = (state == S_IDLE) && start;
    strb.sqInit = (state == S_SQ);
    strb.ldD    = (state == S_LDD);
    strb.accEn  = (state == S_ACC);
    strb.wb     = (state == S_WB);
    strb.fin    = (state == S_FIN);
  end

  // R5: accumulate window never runs past M+1 steps
  p_acc_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACC) |-> (stepCnt <= LAST_STEP));

  // R7: a request during an active inversion does not end or restart it
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_FIN) |=> (state != S_IDLE && state != S_SQ));

  // strobes stay mutually exclusive
  p_strb_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/onbInvDp.sv
module onbInvDp
  import onbInvPkg::*;
#(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  invStrb_t     strb,
  input  logic [M-1:0] opB,
  output logic         done,
  output logic [M-1:0] inv
);

  localparam int P = M + 1;

  logic [M-1:0] tReg, tRot, invPerm;
  logic [P-1:0] dReg, sReg, accReg, permRot, accFix;

  // squaring in normal basis: one cyclic rotation toward the high end
  assign tRot = {tReg[M-2:0], tReg[M-1]};

  // forward map into the cyclic ring (position 0 stays empty) and back
  assign permRot[0] = 1'b0;
  for (genvar i = 0; i < M; i++) begin : g_perm
    localparam int POS = expPos(i, P);
    assign permRot[POS] = tRot[i];
    assign invPerm[i]   = sReg[POS];
  end

  // a set constant term is replaced by the sum of all other positions
  assign accFix = accReg[0] ? ~accReg : accReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tReg   <= '0;
      dReg   <= '0;
      sReg   <= '0;
      accReg <= '0;
      done   <= 1'b0;
      inv    <= '0;
    end else begin
      done <= strb.fin;
      if (strb.ldB) tReg <= opB;
      if (strb.sqInit) begin
        tReg <= tRot;
        sReg <= permRot;
      end
      if (strb.ldD) begin
        tReg   <= tRot;
        dReg   <= permRot;
        accReg <= '0;
      end
      if (strb.accEn) begin
        accReg <= accReg ^ (sReg[0] ? dReg : '0);
        dReg   <= {dReg[P-2:0], dReg[P-1]};
        sReg   <= {1'b0, sReg[P-1:1]};
      end
      if (strb.wb)  sReg <= accFix;
      if (strb.fin) inv  <= invPerm;
    end
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: the published result moves only together with done
  p_res_only_on_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inv) |-> done);

  // R2: the running product never carries a constant term outside accumulation
  p_pos0_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accEn |-> (sReg[0] == 1'b0));

endmodule

// File: rtl/onbInv.sv
module onbInv
  import onbInvPkg::*;
#(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [M-1:0] opB,
  output logic         done,
  output logic [M-1:0] inv
);

  invStrb_t strb;

  onbInvCtrl #(.M(M)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb)
  );

  onbInvDp #(.M(M)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .opB  (opB),
    .done (done),
    .inv  (inv)
  );

endmodule

// File: tb/sim_onbInv.sv
module sim_onbInv;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       start4 = 1'b0, start10 = 1'b0;
  logic [3:0] opB4 = '0, inv4;
  logic [9:0] opB10 = '0, inv10;
  logic       done4, done10;

  onbInv #(.M(4)) u0 (
    .clk(clk), .rstN(rstN), .start(start4), .opB(opB4), .done(done4), .inv(inv4)
  );
  onbInv #(.M(10)) u1 (
    .clk(clk), .rstN(rstN), .start(start10), .opB(opB10), .done(done10), .inv(inv10)
  );

  int checks = 0;
  int errs = 0;
  int cycles = 0;

  function automatic int widthOf(input int w);
    return (w == 0) ? 4 : 10;
  endfunction

  function automatic int latOf(input int m);
    return 2 + (m - 2) * (m + 3);
  endfunction

  function automatic logic [15:0] maskOf(input int m);
    return 16'((32'd1 << m) - 1);
  endfunction

  // normal basis -> polynomial basis modulo 1+x+...+x^m
  function automatic logic [15:0] nb2poly(input logic [15:0] v, input int m);
    logic [15:0] r;
    int e;
    r = '0;
    e = 1;
    for (int i = 0; i < m; i++) begin
      if (v[i]) begin
        if (e == m) r = r ^ maskOf(m);
        else r[e] = r[e] ^ 1'b1;
      end
      e = (e * 2) % (m + 1);
    end
    return r;
  endfunction

  function automatic logic [15:0] poly2nb(input logic [15:0] c, input int m);
    logic [15:0] n;
    int e;
    n = '0;
    e = 1;
    for (int i = 0; i < m; i++) begin
      if (e == m) n[i] = c[0];
      else n[i] = c[e] ^ c[0];
      e = (e * 2) % (m + 1);
    end
    return n;
  endfunction

  function automatic logic [15:0] polyMul(input logic [15:0] a, input logic [15:0] b, input int m);
    logic [15:0] r;
    logic carry;
    r = '0;
    for (int i = m - 1; i >= 0; i--) begin
      carry = r[m-1];
      r = (r << 1) & maskOf(m);
      if (carry) r = r ^ maskOf(m);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [15:0] nbMul(input logic [15:0] a, input logic [15:0] b, input int m);
    return poly2nb(polyMul(nb2poly(a, m), nb2poly(b, m), m), m);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic outDone(input int w);
    return (w == 0) ? done4 : done10;
  endfunction

  function automatic logic [15:0] outInv(input int w);
    return (w == 0) ? 16'(inv4) : 16'(inv10);
  endfunction

  // one inversion; optional intruding start pulse at cycle 'poke' (0 = none)
  task automatic runOp(input int w, input logic [15:0] b, input int poke,
                       input logic [15:0] pokeVal, output logic [15:0] res, output int lat);
    int cyc;
    @(negedge clk);
    if (w == 0) begin opB4 = b[3:0]; start4 = 1'b1; end
    else begin opB10 = b[9:0]; start10 = 1'b1; end
    @(posedge clk); #1;
    start4 = 1'b0; start10 = 1'b0;
    cyc = 1;
    while (!outDone(w) && cyc < 5000) begin
      if (poke != 0 && cyc == poke) begin
        @(negedge clk);
        if (w == 0) begin opB4 = pokeVal[3:0]; start4 = 1'b1; end
        else begin opB10 = pokeVal[9:0]; start10 = 1'b1; end
      end
      @(posedge clk); #1;
      start4 = 1'b0; start10 = 1'b0;
      cyc++;
    end
    res = outInv(w);
    lat = cyc - 1;
  endtask

  task automatic testReset();
    #1;
    check(done4 == 1'b0 && done10 == 1'b0, "R1 done in reset", {15'd0, done4 | done10}, 16'd0);
    check(inv4 == '0 && inv10 == '0, "R1 inv in reset", outInv(1), 16'd0);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(done4 == 1'b0 && done10 == 1'b0, "R1 done after release", {15'd0, done4 | done10}, 16'd0);
    check(inv4 == '0 && inv10 == '0, "R1 inv after release", outInv(0), 16'd0);
  endtask

  // R2 / R8: every nonzero element at both widths
  task automatic testAllElements(input int w);
    logic [15:0] r;
    int lat, m;
    m = widthOf(w);
    for (int b = 1; b <= int'(maskOf(m)); b++) begin
      runOp(w, 16'(b), 0, '0, r, lat);
      check(nbMul(r, 16'(b), m) == maskOf(m), $sformatf("R2 R8 m=%0d b=%0h product", m, b),
            nbMul(r, 16'(b), m), maskOf(m));
      if (b == 1 || b == int'(maskOf(m)))
        check(lat == latOf(m), $sformatf("R5 m=%0d latency", m), 16'(lat), 16'(latOf(m)));
    end
  endtask

  // R3: inverse of inverse
  task automatic testInvolution(input int w, input logic [15:0] b);
    logic [15:0] r1, r2;
    int lat, m;
    m = widthOf(w);
    runOp(w, b, 0, '0, r1, lat);
    runOp(w, r1, 0, '0, r2, lat);
    check(r2 == b, $sformatf("R3 m=%0d double inverse", m), r2, b);
  endtask

  // R4: zero operand
  task automatic testZero(input int w);
    logic [15:0] r;
    int lat, m;
    m = widthOf(w);
    runOp(w, '0, 0, '0, r, lat);
    check(r == '0, $sformatf("R4 m=%0d zero result", m), r, 16'd0);
    check(lat == latOf(m), $sformatf("R4 m=%0d zero latency", m), 16'(lat), 16'(latOf(m)));
  endtask

  // R5 / R6: exact latency, single pulse, held output
  task automatic testPulse(input int w, input logic [15:0] b);
    logic [15:0] r;
    int lat, m;
    m = widthOf(w);
    runOp(w, b, 0, '0, r, lat);
    check(lat == latOf(m), $sformatf("R5 m=%0d exact latency", m), 16'(lat), 16'(latOf(m)));
    @(posedge clk); #1;
    check(outDone(w) == 1'b0, $sformatf("R6 m=%0d done one cycle", m), {15'd0, outDone(w)}, 16'd0);
    repeat (4) @(posedge clk); #1;
    check(outInv(w) == r, $sformatf("R6 m=%0d result held", m), outInv(w), r);
  endtask

  // R7: start while busy
  task automatic testBusyStart(input int w, input logic [15:0] b, input logic [15:0] other);
    logic [15:0] r;
    int lat, m;
    m = widthOf(w);
    runOp(w, b, 5, other, r, lat);
    check(nbMul(r, b, m) == maskOf(m), $sformatf("R7 m=%0d result of first op", m),
          nbMul(r, b, m), maskOf(m));
    check(lat == latOf(m), $sformatf("R7 m=%0d latency unchanged", m), 16'(lat), 16'(latOf(m)));
    repeat (latOf(m) + 4) @(posedge clk); #1;
    check(outInv(w) == r, $sformatf("R7 m=%0d no second result", m), outInv(w), r);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errs++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
      end
    end
  end

  initial begin : main
    testReset();
    testPulse(0, 16'h6);
    testPulse(1, 16'h2b5);
    testZero(0);
    testZero(1);
    testBusyStart(0, 16'h9, 16'h3);
    testBusyStart(1, 16'h151, 16'h0f0);
    testInvolution(0, 16'h5);
    testInvolution(1, 16'h3c7);
    testInvolution(1, 16'h001);
    testAllElements(0);
    testAllElements(1);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule